// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block turns a pending exception, or a hardware interrupt request, into the register updates a processor core needs to enter a handler. Each cycle it samples the current status word, program counter, stack pointer, vector base, the delay-slot and sleep flags, an exception cause code, and the result of an external interrupt priority encoder. It decides whether an event is accepted. If one is, it registers the new status word, the saved status, PC and stack pointer, the handler PC, and the exception or interrupt cause register.

Exceptions win over interrupts. Events that arrive while the status word's block bit is set are either promoted to a reset-class entry or ignored. An event taken in a branch delay slot rewinds the saved PC to the branch. Handler addresses are chosen per event class. A trap-instruction exception saves the address of the following instruction.

The results stay on the outputs until the next accepted event. A one-cycle strobe marks each entry, and the core uses it to clear its sleep state. A second strobe tells the core to clear its delay-slot flags.

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_pend_i` and `irq_req_i` are both high, the exception is taken: `exc_cause_o` is loaded and `irq_cause_o` keeps its value.
- R2: When status bit 28 (block) is set, a pending exception whose code is not 0x1E0 is entered as code 0x000 (cause, status and PC as in R7). Code 0x1E0 is entered unchanged.
- R3: With status bit 28 set and no exception pending, an interrupt request is ignored while `sleep_i` is low, so `taken_o` stays low and all outputs hold. It is accepted while `sleep_i` is high.
- R4: `irq_imask_o` equals status bits 7:4. An interrupt with `irq_vec_valid_i` low is dropped, with no strobe and no output change.
- R5: On entry, `save_status_o` = status, `save_pc_o` = PC (subject to R6/R9) and `save_sp_o` = stack pointer. `status_o` has bits 28, 29 and 30 set, and all other bits are copied unless R7 applies.
- R6: On an entry with `dslot_i` high, `save_pc_o` is PC-2 and `dslot_clr_o` pulses for one cycle. Otherwise `dslot_clr_o` stays low.
- R7: Exception codes 0x000, 0x020 and 0x140 clear status bit 15, set status bits 7:4 to 0xF, and load PC 0xA0000000.
- R8: Exception codes 0x040 and 0x060 load PC vector base+0x400. Every other exception code loads vector base+0x100. `exc_cause_o` receives the entered code.
- R9: Exception code 0x160 adds 2 to the saved PC, on top of any R6 rewind.
- R10: An accepted interrupt loads `irq_cause_o` with `irq_vec_i` and PC with vector base+0x600. `exc_cause_o` holds, and status bits 7:4 and 15 are copied.
- R11: Results appear one clock after the inputs are sampled, and `taken_o` pulses in that cycle. Without an accepted event every output register holds. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| status_i | input | XLEN | Current status word |
| pc_i | input | XLEN | PC of the faulting or interrupted instruction |
| sp_i | input | XLEN | Current stack pointer |
| vec_base_i | input | XLEN | Handler vector base |
| dslot_i | input | 1 | Instruction sits in a branch delay slot |
| sleep_i | input | 1 | Core is in sleep |
| exc_pend_i | input | 1 | An exception code is pending |
| exc_code_i | input | 12 | Pending exception code |
| irq_req_i | input | 1 | Hardware interrupt request |
| irq_imask_o | output | 4 | Current interrupt mask sent to the priority encoder |
| irq_vec_valid_i | input | 1 | Encoder found an unmasked source |
| irq_vec_i | input | 12 | Encoder's interrupt code |
| taken_o | output | 1 | One-cycle entry strobe, also used to clear sleep |
| dslot_clr_o | output | 1 | One-cycle strobe: clear delay-slot flags |
| status_o | output | XLEN | Status word for the handler |
| save_status_o | output | XLEN | Saved status |
| save_pc_o | output | XLEN | Saved return PC |
| save_sp_o | output | XLEN | Saved stack pointer |
| pc_o | output | XLEN | Handler entry PC |
| exc_cause_o | output | 12 | Last entered exception code |
| irq_cause_o | output | 12 | Last entered interrupt code |

## Verification
The hardest cases to reach are the two blocked-mode paths: an interrupt accepted only because the core sleeps, and an exception that the block bit promotes to a reset entry. A third is a trap taken in a delay slot, where the two saved-PC adjustments cancel. The stimulus produces these directly by holding block, sleep and delay-slot flags together with the matching codes. A randomized phase then mixes block and sleep bits, codes drawn from every handler class and interrupt requests with and without a valid vector. A behavioural model checks every output every cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CODE_W   = 12;
  localparam int SR_BL    = 28;
  localparam int SR_RB    = 29;
  localparam int SR_MD    = 30;
  localparam int SR_FD    = 15;
  localparam int SR_IM_LO = 4;
  localparam int SR_IM_W  = 4;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t C_POWER    = 12'h000;
  localparam code_t C_MANUAL   = 12'h020;
  localparam code_t C_MULTI    = 12'h140;
  localparam code_t C_TLB_RD   = 12'h040;
  localparam code_t C_TLB_WR   = 12'h060;
  localparam code_t C_TRAP     = 12'h160;
  localparam code_t C_BLK_PASS = 12'h1E0;

  typedef enum logic [1:0] {EV_NONE, EV_EXC, EV_IRQ} ev_kind_e;

  function automatic logic is_reset_grp(code_t c);
    return (c == C_POWER) || (c == C_MANUAL) || (c == C_MULTI);
  endfunction

  function automatic logic is_tlb_miss(code_t c);
    return (c == C_TLB_RD) || (c == C_TLB_WR);
  endfunction
endpackage

// File: rtl/exc_accept.sv
module exc_accept
  import exc_entry_pkg::*;
(
  input  logic     exc_pend_i,
  input  code_t    exc_code_i,
  input  logic     irq_req_i,
  input  logic     irq_vec_valid_i,
  input  logic     blocked_i,
  input  logic     sleep_i,
  output ev_kind_e kind_o,
  output code_t    code_o
);
  always_comb begin
    kind_o = EV_NONE;
    code_o = exc_code_i;
    if (exc_pend_i) begin
      kind_o = EV_EXC;
      // blocked exceptions escalate to reset, except the pass-through code
      if (blocked_i && exc_code_i != C_BLK_PASS) code_o = C_POWER;
    end else if (irq_req_i && irq_vec_valid_i && (!blocked_i || sleep_i)) begin
      kind_o = EV_IRQ;
    end
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_entry_pkg::*;
#(
  parameter int                XLEN     = 32,
  parameter logic [XLEN-1:0]   RESET_PC = 32'hA000_0000,
  parameter logic [XLEN-1:0]   OFS_GEN  = 32'h100,
  parameter logic [XLEN-1:0]   OFS_TLB  = 32'h400,
  parameter logic [XLEN-1:0]   OFS_IRQ  = 32'h600
) (
  input  ev_kind_e          kind_i,
  input  code_t             code_i,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   vec_base_i,
  input  logic              dslot_i,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   ret_pc_o,
  output logic [XLEN-1:0]   pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(2);

  always_comb begin
    ret_pc_o = pc_i;
    if (dslot_i) ret_pc_o = ret_pc_o - STEP;
    if (kind_i == EV_EXC && code_i == C_TRAP) ret_pc_o = ret_pc_o + STEP;

    status_o        = status_i;
    status_o[SR_BL] = 1'b1;
    status_o[SR_MD] = 1'b1;
    status_o[SR_RB] = 1'b1;

    pc_o = vec_base_i + OFS_GEN;
    unique case (kind_i)
      EV_EXC: begin
        if (is_reset_grp(code_i)) begin
          status_o[SR_FD]               = 1'b0;
          status_o[SR_IM_LO +: SR_IM_W] = '1;
          pc_o                          = RESET_PC;
        end else if (is_tlb_miss(code_i)) begin
          pc_o = vec_base_i + OFS_TLB;
        end
      end
      EV_IRQ:  pc_o = vec_base_i + OFS_IRQ;
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int                XLEN     = 32,
  parameter logic [XLEN-1:0]   RESET_PC = 32'hA000_0000,
  parameter logic [XLEN-1:0]   OFS_GEN  = 32'h100,
  parameter logic [XLEN-1:0]   OFS_TLB  = 32'h400,
  parameter logic [XLEN-1:0]   OFS_IRQ  = 32'h600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   sp_i,
  input  logic [XLEN-1:0]   vec_base_i,
  input  logic              dslot_i,
  input  logic              sleep_i,
  input  logic              exc_pend_i,
  input  logic [11:0]       exc_code_i,
  input  logic              irq_req_i,
  output logic [3:0]        irq_imask_o,
  input  logic              irq_vec_valid_i,
  input  logic [11:0]       irq_vec_i,
  output logic              taken_o,
  output logic              dslot_clr_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   save_status_o,
  output logic [XLEN-1:0]   save_pc_o,
  output logic [XLEN-1:0]   save_sp_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [11:0]       exc_cause_o,
  output logic [11:0]       irq_cause_o
);
  ev_kind_e        kind;
  code_t           code_eff;
  logic [XLEN-1:0] status_n, ret_pc_n, pc_n;
  logic            take;

  assign irq_imask_o = status_i[SR_IM_LO +: SR_IM_W];

  exc_accept u_accept (
    .exc_pend_i      (exc_pend_i),
    .exc_code_i      (exc_code_i),
    .irq_req_i       (irq_req_i),
    .irq_vec_valid_i (irq_vec_valid_i),
    .blocked_i       (status_i[SR_BL]),
    .sleep_i         (sleep_i),
    .kind_o          (kind),
    .code_o          (code_eff)
  );

  exc_target #(
    .XLEN(XLEN), .RESET_PC(RESET_PC), .OFS_GEN(OFS_GEN),
    .OFS_TLB(OFS_TLB), .OFS_IRQ(OFS_IRQ)
  ) u_target (
    .kind_i     (kind),
    .code_i     (code_eff),
    .status_i   (status_i),
    .pc_i       (pc_i),
    .vec_base_i (vec_base_i),
    .dslot_i    (dslot_i),
    .status_o   (status_n),
    .ret_pc_o   (ret_pc_n),
    .pc_o       (pc_n)
  );

  assign take = (kind != EV_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o       <= 1'b0;
      dslot_clr_o   <= 1'b0;
      status_o      <= '0;
      save_status_o <= '0;
      save_pc_o     <= '0;
      save_sp_o     <= '0;
      pc_o          <= '0;
      exc_cause_o   <= '0;
      irq_cause_o   <= '0;
    end else begin
      taken_o     <= take;
      dslot_clr_o <= take && dslot_i;
      if (take) begin
        status_o      <= status_n;
        save_status_o <= status_i;
        save_pc_o     <= ret_pc_n;
        save_sp_o     <= sp_i;
        pc_o          <= pc_n;
        if (kind == EV_EXC) exc_cause_o <= code_eff;
        if (kind == EV_IRQ) irq_cause_o <= irq_vec_i;
      end
    end
  end

  a_r1_exc_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_pend_i |=> taken_o && $stable(irq_cause_o));

  a_r3_blocked_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[SR_BL] && !exc_pend_i && !sleep_i) |=> !taken_o);

  a_r4_no_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_pend_i && !irq_vec_valid_i) |=> !taken_o);

  a_r5_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> save_status_o == $past(status_i) && save_sp_o == $past(sp_i)
               && status_o[SR_BL] && status_o[SR_MD] && status_o[SR_RB]);

  a_r10_irq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && !$past(exc_pend_i)) |-> pc_o == $past(vec_base_i) + OFS_IRQ);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> $stable(pc_o) && $stable(status_o) && $stable(save_pc_o) && !dslot_clr_o);
endmodule

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [31:0] t_sr, t_pc, t_sp, t_vbr;
  logic        t_ds, t_sl, t_ep, t_irq, t_vv;
  logic [11:0] t_code, t_vec;

  logic [3:0]  imask;
  logic        taken, dclr;
  logic [31:0] sr_o, ssr_o, spc_o, sgr_o, pc_o;
  logic [11:0] exp_o, int_o;

  exc_entry_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .status_i(t_sr), .pc_i(t_pc), .sp_i(t_sp),
    .vec_base_i(t_vbr), .dslot_i(t_ds), .sleep_i(t_sl), .exc_pend_i(t_ep),
    .exc_code_i(t_code), .irq_req_i(t_irq), .irq_imask_o(imask),
    .irq_vec_valid_i(t_vv), .irq_vec_i(t_vec), .taken_o(taken),
    .dslot_clr_o(dclr), .status_o(sr_o), .save_status_o(ssr_o),
    .save_pc_o(spc_o), .save_sp_o(sgr_o), .pc_o(pc_o),
    .exc_cause_o(exp_o), .irq_cause_o(int_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic        m_tk, m_dc;
  logic [31:0] m_sr, m_ssr, m_spc, m_sgr, m_pc;
  logic [11:0] m_exp, m_int;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "taken", 32'(taken), 32'(m_tk));
    chk(tag, "dslot_clr", 32'(dclr), 32'(m_dc));
    chk(tag, "status", sr_o, m_sr);
    chk(tag, "save_status", ssr_o, m_ssr);
    chk(tag, "save_pc", spc_o, m_spc);
    chk(tag, "save_sp", sgr_o, m_sgr);
    chk(tag, "pc", pc_o, m_pc);
    chk(tag, "exc_cause", 32'(exp_o), 32'(m_exp));
    chk(tag, "irq_cause", 32'(int_o), 32'(m_int));
    chk("R4", "imask", 32'(imask), 32'(t_sr[7:4]));
  endtask

  // behavioural reference: next register contents from current inputs
  task automatic model();
    int code;
    bit blk, acc_exc, acc_irq;
    blk = t_sr[28];
    code = int'(t_code);
    acc_exc = t_ep;
    acc_irq = !t_ep && t_irq && t_vv && (!blk || t_sl);
    if (acc_exc && blk && code != 'h1E0) code = 0;
    m_tk = acc_exc || acc_irq;
    m_dc = m_tk && t_ds;
    if (m_tk) begin
      m_ssr = t_sr;
      m_sgr = t_sp;
      m_spc = t_ds ? t_pc - 2 : t_pc;
      m_sr  = t_sr | 32'h7000_0000;
      if (acc_exc) begin
        m_exp = 12'(code);
        if (code == 'h000 || code == 'h020 || code == 'h140) begin
          m_sr[15]  = 1'b0;
          m_sr[7:4] = 4'hF;
          m_pc = 32'hA000_0000;
        end else if (code == 'h040 || code == 'h060) begin
          m_pc = t_vbr + 32'h400;
        end else begin
          if (code == 'h160) m_spc = m_spc + 2;
          m_pc = t_vbr + 32'h100;
        end
      end else begin
        m_int = t_vec;
        m_pc  = t_vbr + 32'h600;
      end
    end
  endtask

  task automatic cycle(input string tag);
    model();
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle();
    t_ep = 0; t_irq = 0; t_vv = 0;
  endtask

  task automatic ev(input string tag, input logic [31:0] sr, input logic [31:0] pc,
                    input logic ds, input logic sl, input logic ep, input logic [11:0] code,
                    input logic irq, input logic vv, input logic [11:0] vec);
    t_sr = sr; t_pc = pc; t_sp = pc ^ 32'h5A5A_0000; t_vbr = 32'h8C00_0000 + {pc[7:0], 8'h0};
    t_ds = ds; t_sl = sl; t_ep = ep; t_code = code; t_irq = irq; t_vv = vv; t_vec = vec;
    cycle(tag);
    idle();
    cycle("R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_sr = 0; t_pc = 0; t_sp = 0; t_vbr = 0; t_ds = 0; t_sl = 0;
    t_code = 0; t_vec = 0; idle();
    m_tk = 0; m_dc = 0; m_sr = 0; m_ssr = 0; m_spc = 0; m_sgr = 0; m_pc = 0;
    m_exp = 0; m_int = 0;
    repeat (3) @(negedge clk);
    compare_all("R11");  // reset state
    rst_n = 1;
    @(negedge clk);
    compare_all("R11");

    ev("R8", 32'h0000_00F0, 32'h0C00_1000, 0, 0, 1, 12'h0A0, 0, 0, 0);
    ev("R8", 32'h0000_0030, 32'h0C00_1010, 0, 0, 1, 12'h040, 0, 0, 0);
    ev("R8", 32'h0000_0030, 32'h0C00_1020, 0, 0, 1, 12'h060, 0, 0, 0);
    ev("R7", 32'h0000_8020, 32'h0C00_1030, 0, 0, 1, 12'h020, 0, 0, 0);
    ev("R7", 32'h0000_8000, 32'h0C00_1040, 0, 0, 1, 12'h140, 0, 0, 0);
    ev("R9", 32'h0000_0000, 32'h0C00_1050, 0, 0, 1, 12'h160, 0, 0, 0);
    ev("R9", 32'h0000_0000, 32'h0C00_1060, 1, 0, 1, 12'h160, 0, 0, 0);
    ev("R6", 32'h0000_0010, 32'h0C00_1070, 1, 0, 1, 12'h0A0, 0, 0, 0);
    ev("R1", 32'h0000_0000, 32'h0C00_1080, 0, 0, 1, 12'h180, 1, 1, 12'h3C0);
    ev("R2", 32'h1000_8000, 32'h0C00_1090, 0, 0, 1, 12'h0A0, 0, 0, 0);
    ev("R2", 32'h1000_0000, 32'h0C00_10A0, 0, 0, 1, 12'h1E0, 0, 0, 0);
    ev("R3", 32'h1000_0000, 32'h0C00_10B0, 0, 0, 0, 12'h000, 1, 1, 12'h200);
    ev("R3", 32'h1000_0000, 32'h0C00_10C0, 0, 1, 0, 12'h000, 1, 1, 12'h220);
    ev("R4", 32'h0000_00A0, 32'h0C00_10D0, 0, 0, 0, 12'h000, 1, 0, 12'h240);
    ev("R10", 32'h0000_80A0, 32'h0C00_10E0, 1, 0, 0, 12'h000, 1, 1, 12'h260);
    ev("R5", 32'hF0F0_0F0F, 32'h0C00_10F0, 0, 0, 1, 12'h100, 0, 0, 0);

    for (int i = 0; i < 600; i++) begin
      logic [11:0] c;
      case ($urandom % 10)
        0: c = 12'h000; 1: c = 12'h020; 2: c = 12'h140; 3: c = 12'h040;
        4: c = 12'h060; 5: c = 12'h160; 6: c = 12'h1E0; 7: c = 12'h0E0;
        8: c = 12'h100; default: c = 12'h180;
      endcase
      t_sr = $urandom; t_pc = $urandom & 32'hFFFF_FFFE; t_sp = $urandom; t_vbr = $urandom & 32'hFFFF_F000;
      t_ds = 1'($urandom); t_sl = 1'($urandom); t_ep = ($urandom % 3) == 0;
      t_code = c; t_irq = 1'($urandom); t_vv = 1'($urandom); t_vec = 12'($urandom) & 12'hFE0;
      cycle(t_ep ? "R8" : "R10");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule